// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self-test of an eight-character dot-matrix display controller. A write that sets the self-test bit of the control word raises `start_i` for one cycle. The sequencer then reads every row of every glyph in the character decoder ROM through a lookup port and adds the 5-bit dot patterns into a 16-bit checksum. At the end of the walk it compares that checksum with the `EXP_SUM` parameter, and the result becomes the pass flag.

Two visual phases follow. First the LED drive shows a checkerboard, then the inverse checkerboard, each for the same number of cycles. The phase lengths are chosen so that the whole test lasts exactly 2^`TOTAL_LOG2` clocks (262,144 by default). In the final busy cycle `done_o` pulses and the post-test register image is presented for the surrounding register file to load: the control word cleared except for the pass bit, the user-glyph address register set to all ones, the character RAM filled with the space code, and the flash RAM cleared. The host must not access the display while `busy_o` is high.

Top module: `disp_bist_seq`

## Requirements
- R1: During and after reset, busy_o, done_o, pass_o, rom_rd_o, pattern_on_o and pattern_inv_o are 0, and ctrl_word_o, udc_addr_o and char_fill_o are 0.
- R2: A start_i pulse while idle makes busy_o high from the next cycle for exactly 2^TOTAL_LOG2 cycles. done_o is high only in the last of those cycles.
- R3: The first CODES*ROWS busy cycles form the ROM walk. rom_rd_o is high and the address steps row-minor: code 0 rows 0..ROWS-1, then code 1, and so on. rom_data_i is sampled in the same cycle.
- R4: pass_o clears to 0 in the first busy cycle. In the cycle after the walk it becomes 1 exactly when the 16-bit wrapping sum of all sampled 5-bit rows equals EXP_SUM, and 0 otherwise.
- R5: After the walk, pattern_on_o is high for the rest of the test. pattern_inv_o is 0 for the first PAT_LEN = 2^(TOTAL_LOG2-1) - CODES*ROWS/2 of those cycles and 1 for the final PAT_LEN cycles. Both are 0 when idle.
- R6: While done_o is high, ctrl_word_o equals pass_o shifted to bit 5 (all other bits 0), udc_addr_o is 8'hFF and char_fill_o is 8'h20. The same pulse clears the flash RAM. Outside done_o these three outputs are 0.
- R7: start_i pulses while busy_o is high are ignored, and the test ends on the original schedule.
- R8: An rst_n assertion during a test aborts it immediately, and the outputs return to the R1 state.
- R9: After the test, pass_o keeps its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: the self-test bit was written |
| rom_rd_o | output | 1 | ROM lookup active (walk phase) |
| rom_code_o | output | 7 | Glyph code being looked up |
| rom_row_o | output | 3 | Glyph row being looked up |
| rom_data_i | input | 5 | Row dot pattern returned by the ROM, same cycle |
| busy_o | output | 1 | Self-test in progress; host access forbidden |
| pattern_on_o | output | 1 | Drive the checkerboard onto all dots |
| pattern_inv_o | output | 1 | Use the inverse checkerboard |
| done_o | output | 1 | Final cycle of the test; commit the post-test image |
| pass_o | output | 1 | Checksum result (control word bit 5) |
| ctrl_word_o | output | 8 | Control word to load on done_o |
| udc_addr_o | output | 8 | User-glyph address register value to load on done_o |
| char_fill_o | output | 8 | Code to fill the character RAM with on done_o |

## Verification
A wrong walk counter shows on rom_code_o/rom_row_o in the very cycle it goes wrong. A wrong checksum shows one cycle after the walk, as a pass_o that disagrees with the sum the bench forms from its own ROM model. An off-by-one in a phase counter moves the pattern_inv_o edge or the done_o pulse away from the cycle the bench expects. A state machine that re-arms on a stray start shows as busy_o staying high past 2^TOTAL_LOG2 cycles. The bench runs a reduced TOTAL_LOG2 so that every one of these outputs can be compared in every cycle of several complete tests.

// File: rtl/disp_bist_pkg.sv
package disp_bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_PAT_A = 2'd2,
        ST_PAT_B = 2'd3
    } bist_state_e;

    localparam int CW_WIDTH    = 8;
    localparam int CW_PASS_BIT = 5;
    localparam logic [7:0] BLANK_CODE = 8'h20;

endpackage

// File: rtl/disp_bist_walk.sv
module disp_bist_walk #(
    parameter int CODES  = 128,
    parameter int ROWS   = 7,
    parameter int DOT_W  = 5,
    parameter int SUM_W  = 16,
    parameter int CODE_W = $clog2(CODES),
    parameter int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [DOT_W-1:0]  rom_data_i,
    output logic [CODE_W-1:0] code_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              last_o,
    output logic [SUM_W-1:0]  sum_o
);

    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(CODES - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ROW_W-1:0]  row;
        logic [SUM_W-1:0]  sum;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  row_end;

    always_comb begin
        walk_d  = walk_q;
        row_end = (walk_q.row == LAST_ROW);
        last_o  = row_end && (walk_q.code == LAST_CODE);
        sum_o   = walk_q.sum + SUM_W'(rom_data_i);
        if (clear_i) begin
            walk_d = '0;
        end else if (step_i) begin
            walk_d.sum = sum_o;
            if (row_end) begin
                walk_d.row  = '0;
                walk_d.code = walk_q.code + 1'b1;
            end else begin
                walk_d.row = walk_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign code_o = walk_q.code;
    assign row_o  = walk_q.row;

    // R3: inside a glyph the row advances by one and the code holds
    assert_row_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && (row_o != LAST_ROW))
        |=> (row_o == $past(row_o) + 1'b1) && (code_o == $past(code_o)));

    // R3: at the end of a glyph the next code starts at row 0
    assert_code_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && (row_o == LAST_ROW))
        |=> (row_o == '0) && (code_o == $past(code_o) + 1'b1));

endmodule

// File: rtl/disp_bist_pat.sv
module disp_bist_pat #(
    parameter int CNT_W   = 17,
    parameter int PAT_LEN = 130624
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PAT_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pat_t;

    pat_t pat_d, pat_q;

    always_comb begin
        pat_d  = pat_q;
        last_o = (pat_q.cnt == LAST_CNT);
        if (clear_i) begin
            pat_d.cnt = '0;
        end else if (step_i) begin
            pat_d.cnt = last_o ? '0 : pat_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= '0;
        else        pat_q <= pat_d;
    end

    // R5: a phase end is followed by a fresh count, never a second end
    assert_pat_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && step_i && !clear_i) |=> !last_o);

endmodule

// File: rtl/disp_bist_seq.sv
module disp_bist_seq
    import disp_bist_pkg::*;
#(
    parameter int          CODES      = 128,
    parameter int          ROWS       = 7,
    parameter int          DOT_W      = 5,
    parameter int          SUM_W      = 16,
    parameter int          TOTAL_LOG2 = 18,
    parameter logic [15:0] EXP_SUM    = 16'h0000,
    parameter int          CODE_W     = $clog2(CODES),
    parameter int          ROW_W      = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              rom_rd_o,
    output logic [CODE_W-1:0] rom_code_o,
    output logic [ROW_W-1:0]  rom_row_o,
    input  logic [DOT_W-1:0]  rom_data_i,
    output logic              busy_o,
    output logic              pattern_on_o,
    output logic              pattern_inv_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [7:0]        ctrl_word_o,
    output logic [7:0]        udc_addr_o,
    output logic [7:0]        char_fill_o
);

    localparam int WALK_LEN = CODES * ROWS;
    localparam int TOTAL    = 2 ** TOTAL_LOG2;
    localparam int PAT_LEN  = (TOTAL / 2) - (WALK_LEN / 2);
    localparam int PAT_W    = TOTAL_LOG2 - 1;

    typedef struct packed {
        bist_state_e st;
        logic        pass;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             clear;
    logic             walk_step, walk_last;
    logic             pat_step, pat_last;
    logic [SUM_W-1:0] sum_next;

    disp_bist_walk #(
        .CODES (CODES),
        .ROWS  (ROWS),
        .DOT_W (DOT_W),
        .SUM_W (SUM_W),
        .CODE_W(CODE_W),
        .ROW_W (ROW_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .step_i    (walk_step),
        .rom_data_i(rom_data_i),
        .code_o    (rom_code_o),
        .row_o     (rom_row_o),
        .last_o    (walk_last),
        .sum_o     (sum_next)
    );

    disp_bist_pat #(
        .CNT_W  (PAT_W),
        .PAT_LEN(PAT_LEN)
    ) u_pat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear),
        .step_i (pat_step),
        .last_o (pat_last)
    );

    always_comb begin
        seq_d     = seq_q;
        clear     = (seq_q.st == ST_IDLE) && start_i;
        walk_step = (seq_q.st == ST_WALK);
        pat_step  = (seq_q.st == ST_PAT_A) || (seq_q.st == ST_PAT_B);
        unique case (seq_q.st)
            ST_IDLE: if (start_i) begin
                seq_d.st   = ST_WALK;
                seq_d.pass = 1'b0;
            end
            ST_WALK: if (walk_last) begin
                seq_d.st   = ST_PAT_A;
                seq_d.pass = (sum_next == SUM_W'(EXP_SUM));
            end
            ST_PAT_A: if (pat_last) seq_d.st = ST_PAT_B;
            ST_PAT_B: if (pat_last) seq_d.st = ST_IDLE;
            default:  seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, pass: 1'b0};
        else        seq_q <= seq_d;
    end

    assign busy_o        = (seq_q.st != ST_IDLE);
    assign rom_rd_o      = walk_step;
    assign pattern_on_o  = pat_step;
    assign pattern_inv_o = (seq_q.st == ST_PAT_B);
    assign done_o        = (seq_q.st == ST_PAT_B) && pat_last;
    assign pass_o        = seq_q.pass;
    assign ctrl_word_o   = done_o ? (8'(seq_q.pass) << CW_PASS_BIT) : 8'h00;
    assign udc_addr_o    = done_o ? 8'hFF : 8'h00;
    assign char_fill_o   = done_o ? BLANK_CODE : 8'h00;

    // Busy-cycle counter used only by the length check below
    logic [TOTAL_LOG2:0] busy_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_cyc_q <= '0;
        else if (busy_o) busy_cyc_q <= busy_cyc_q + 1'b1;
        else             busy_cyc_q <= '0;
    end

    // R2: the done pulse lands in busy cycle number TOTAL
    assert_total_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cyc_q == (TOTAL_LOG2 + 1)'(TOTAL - 1)));

    // R2: the test ends right after done
    assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R7: nothing but done ends a running test
    assert_no_early_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R5: the plain checkerboard always comes first
    assert_pat_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pattern_on_o) |-> !pattern_inv_o);

    // R9: the result is frozen during the pattern phases
    assert_pass_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_on_o && $past(pattern_on_o)) |-> $stable(pass_o));

endmodule

// File: tb/disp_bist_seq_tb.sv
module disp_bist_seq_tb;

    localparam int CODES = 128;
    localparam int ROWS  = 7;
    localparam int TL2   = 12;
    localparam int TOTAL = 2 ** TL2;
    localparam int WALK  = CODES * ROWS;
    localparam int PAT   = TOTAL / 2 - WALK / 2;

    function automatic logic [4:0] rom_f(input int c, input int r);
        return 5'(((c * 7) + (r * 13) + ((c >> 2) * 5)) ^ (r << 1));
    endfunction

    function automatic logic [15:0] calc_sum();
        logic [15:0] s = 16'h0;
        for (int c = 0; c < CODES; c++)
            for (int r = 0; r < ROWS; r++)
                s = s + 16'(rom_f(c, r));
        return s;
    endfunction

    localparam logic [15:0] EXP = calc_sum();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rom_rd_o, busy_o, pattern_on_o, pattern_inv_o, done_o, pass_o;
    logic [6:0] rom_code_o;
    logic [2:0] rom_row_o;
    logic [4:0] rom_data_i;
    logic [7:0] ctrl_word_o, udc_addr_o, char_fill_o;

    logic       cor_en = 1'b0;
    int         cor_c = 0, cor_r = 0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign rom_data_i = rom_f(int'(rom_code_o), int'(rom_row_o)) ^
        {4'b0, (cor_en && int'(rom_code_o) == cor_c && int'(rom_row_o) == cor_r)};

    disp_bist_seq #(
        .CODES(CODES), .ROWS(ROWS), .DOT_W(5), .SUM_W(16),
        .TOTAL_LOG2(TL2), .EXP_SUM(EXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rom_rd_o(rom_rd_o), .rom_code_o(rom_code_o), .rom_row_o(rom_row_o),
        .rom_data_i(rom_data_i), .busy_o(busy_o), .pattern_on_o(pattern_on_o),
        .pattern_inv_o(pattern_inv_o), .done_o(done_o), .pass_o(pass_o),
        .ctrl_word_o(ctrl_word_o), .udc_addr_o(udc_addr_o), .char_fill_o(char_fill_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "busy", int'(busy_o), 0);
        chk(req, "done", int'(done_o), 0);
        chk(req, "rom_rd", int'(rom_rd_o), 0);
        chk(req, "pattern_on", int'(pattern_on_o), 0);
        chk(req, "pattern_inv", int'(pattern_inv_o), 0);
        chk(req, "ctrl_word", int'(ctrl_word_o), 0);
        chk(req, "udc_addr", int'(udc_addr_o), 0);
        chk(req, "char_fill", int'(char_fill_o), 0);
    endtask

    // Full test from a start pulse, checked every cycle
    task automatic run_test(input bit corrupt, input bit spam);
        int exp_pass;
        cor_en   = corrupt;
        cor_c    = int'($urandom % CODES);
        cor_r    = int'($urandom % ROWS);
        exp_pass = corrupt ? 0 : 1;
        @(negedge clk);
        start_i = 1'b1;
        for (int k = 1; k <= TOTAL + 3; k++) begin
            @(negedge clk);
            start_i = (spam && k <= TOTAL) ? ($urandom % 8 == 0) : 1'b0;
            chk("R2", "busy", int'(busy_o), (k <= TOTAL) ? 1 : 0);
            chk("R2", "done", int'(done_o), (k == TOTAL) ? 1 : 0);
            chk("R3", "rom_rd", int'(rom_rd_o), (k <= WALK) ? 1 : 0);
            if (k <= WALK) begin
                chk("R3", "code", int'(rom_code_o), (k - 1) / ROWS);
                chk("R3", "row", int'(rom_row_o), (k - 1) % ROWS);
            end
            chk("R5", "pattern_on", int'(pattern_on_o), (k > WALK && k <= TOTAL) ? 1 : 0);
            chk("R5", "pattern_inv", int'(pattern_inv_o), (k > WALK + PAT && k <= TOTAL) ? 1 : 0);
            if (k <= WALK) chk("R4", "pass during walk", int'(pass_o), 0);
            else if (k <= TOTAL) chk("R4", "pass result", int'(pass_o), exp_pass);
            else chk("R9", "pass held", int'(pass_o), exp_pass);
            chk("R6", "ctrl_word", int'(ctrl_word_o), (k == TOTAL) ? (exp_pass << 5) : 0);
            chk("R6", "udc_addr", int'(udc_addr_o), (k == TOTAL) ? 255 : 0);
            chk("R6", "char_fill", int'(char_fill_o), (k == TOTAL) ? 32 : 0);
        end
        cor_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20251));
        #1;
        chk_idle("R1");
        chk("R1", "pass in reset", int'(pass_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        chk("R1", "pass after reset", int'(pass_o), 0);

        run_test(1'b0, 1'b0);   // R4 matching checksum
        run_test(1'b1, 1'b0);   // R4 one corrupted row -> fail
        run_test(1'b0, 1'b1);   // R7 stray starts while busy
        run_test(1'b1, 1'b1);

        // R8: abort in mid-test via reset
        run_test(1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (900 + int'($urandom % 3000)) @(negedge clk);
        chk("R8", "busy before abort", int'(busy_o), 1);
        rst_n = 1'b0;
        #1;
        chk_idle("R8");
        chk("R8", "pass on abort", int'(pass_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R8");

        run_test(1'b0, 1'b0);   // full test after the abort
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule